// File: doc/BRIEF.md
# Segment Base-Limit Address Translator

This block turns a logical address coming from a processor into a physical address by treating it as an offset into one active memory segment. The segment is described by a base and a size. Both are arbitrary values: the base need not be aligned and the size need not be a power of two. The physical address is the base plus the offset. An offset that falls outside the segment, or a sum that overflows the physical address width, is reported as a fault instead of an address.

The segment description is held in one register that is written through a single-cycle load port. Requests arrive on a valid/ready interface. Results leave from a registered output stage with its own valid/ready pair, so a translation appears one cycle after its request was accepted. While the consumer stalls, the result is held steady and no new request is taken.

Top module: `seg_xlate`

## Requirements
- R1: After reset `rsp_valid` is 0, `req_ready` is 1, and the segment register holds base 0 and size 0, so every request faults until a segment is loaded.
- R2: When `req_offset` < size and base + offset fits in `PA_W` bits, the response carries `rsp_fault` = 0 and `rsp_paddr` = base + offset.
- R3: When `req_offset` >= size, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0. An offset of size - 1 is still in range.
- R4: When base + offset carries out of `PA_W` bits, the response carries `rsp_fault` = 1 and `rsp_paddr` = 0, even if the offset is within the size.
- R5: A load on `seg_wr` takes effect from the next cycle. A request accepted in the same cycle as the load is translated with the old base and size.
- R6: A request accepted on a rising edge (`req_valid` and `req_ready` both 1) produces `rsp_valid` = 1 immediately after that edge.
- R7: While `rsp_valid` is 1 and `rsp_ready` is 0, `req_ready` is 0 and `rsp_valid`, `rsp_paddr` and `rsp_fault` stay unchanged. When `rsp_ready` is 1 and no request is accepted, `rsp_valid` drops after the edge.
- R8: A faulting request leaves the segment register unchanged, so a later in-range request is translated with the same base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_wr | input | 1 | Load strobe for the segment register |
| seg_base_in | input | PA_W | New segment base |
| seg_size_in | input | LA_W+1 | New segment size in addressable units |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_offset | input | LA_W | Logical address, used as the offset |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 1 | Offset outside the segment or address overflow |

## Verification
A corrupted base shows up as a wrong `rsp_paddr` on the very next accepted in-range request, and a corrupted size shows up as a wrongly set or wrongly cleared `rsp_fault` at the boundary offsets. A bad output-stage state shows up within one cycle as a dropped, duplicated or changing response during a stall. A write that lands one cycle early or late is exposed by a request issued in the same cycle as the load, whose result must still reflect the old segment.

// File: rtl/seg_pkg.sv
package seg_pkg;
    // default widths shared by the translator and its checker
    parameter int unsigned SEG_LA_W = 16;
    parameter int unsigned SEG_PA_W = 20;

    // outcome of one translation
    typedef enum logic [1:0] {
        XL_OK    = 2'd0,
        XL_RANGE = 2'd1,
        XL_WRAP  = 2'd2
    } xl_cause_e;
endpackage

// File: rtl/seg_reg.sv
module seg_reg #(
    parameter int unsigned LA_W = seg_pkg::SEG_LA_W,
    parameter int unsigned PA_W = seg_pkg::SEG_PA_W,
    localparam int unsigned SZ_W = LA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr,
    input  logic [PA_W-1:0] base_in,
    input  logic [SZ_W-1:0] size_in,
    output logic [PA_W-1:0] base_q,
    output logic [SZ_W-1:0] size_q
);
    typedef struct packed {
        logic [PA_W-1:0] base;
        logic [SZ_W-1:0] size;
    } seg_t;

    seg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr) begin
            st_d.base = base_in;
            st_d.size = size_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_q = st_q.base;
    assign size_q = st_q.size;
endmodule

// File: rtl/seg_calc.sv
module seg_calc
    import seg_pkg::*;
#(
    parameter int unsigned LA_W = seg_pkg::SEG_LA_W,
    parameter int unsigned PA_W = seg_pkg::SEG_PA_W,
    localparam int unsigned SZ_W = LA_W + 1,
    localparam int unsigned EXT_W = LA_W + 1
) (
    input  logic [PA_W-1:0] base,
    input  logic [SZ_W-1:0] size,
    input  logic [LA_W-1:0] offset,
    output logic [PA_W-1:0] paddr,
    output xl_cause_e       cause
);
    logic [PA_W:0]     sum;
    logic [EXT_W-1:0]  off_ext;
    logic              out_of_range;

    generate
        if (PA_W >= LA_W) begin : g_wide
            assign sum = {1'b0, base} + {{(PA_W-LA_W+1){1'b0}}, offset};
        end else begin : g_narrow
            assign sum = {1'b0, base} + (PA_W+1)'(offset);
        end
    endgenerate

    assign off_ext      = {1'b0, offset};
    assign out_of_range = (off_ext >= size);

    always_comb begin
        paddr = '0;
        cause = XL_OK;
        if (out_of_range)    cause = XL_RANGE;
        else if (sum[PA_W])  cause = XL_WRAP;
        else                 paddr = sum[PA_W-1:0];
    end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int unsigned LA_W = seg_pkg::SEG_LA_W,
    parameter int unsigned PA_W = seg_pkg::SEG_PA_W,
    localparam int unsigned SZ_W = LA_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            seg_wr,
    input  logic [PA_W-1:0] seg_base_in,
    input  logic [SZ_W-1:0] seg_size_in,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [LA_W-1:0] req_offset,
    output logic            rsp_valid,
    input  logic            rsp_ready,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            rsp_fault
);
    typedef struct packed {
        logic            valid;
        logic            fault;
        logic [PA_W-1:0] paddr;
    } out_t;

    logic [PA_W-1:0] cur_base;
    logic [SZ_W-1:0] cur_size;
    logic [PA_W-1:0] calc_paddr;
    xl_cause_e       calc_cause;
    logic            accept;

    out_t out_d, out_q;

    seg_reg #(.LA_W(LA_W), .PA_W(PA_W)) u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (seg_wr),
        .base_in (seg_base_in),
        .size_in (seg_size_in),
        .base_q  (cur_base),
        .size_q  (cur_size)
    );

    seg_calc #(.LA_W(LA_W), .PA_W(PA_W)) u_calc (
        .base   (cur_base),
        .size   (cur_size),
        .offset (req_offset),
        .paddr  (calc_paddr),
        .cause  (calc_cause)
    );

    assign req_ready = !out_q.valid || rsp_ready;
    assign accept    = req_valid && req_ready;

    always_comb begin
        out_d = out_q;
        if (accept) begin
            out_d.valid = 1'b1;
            out_d.fault = (calc_cause != XL_OK);
            out_d.paddr = calc_paddr;
        end else if (rsp_ready) begin
            out_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rsp_valid = out_q.valid;
    assign rsp_fault = out_q.fault;
    assign rsp_paddr = out_q.paddr;
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int unsigned LA_W = seg_pkg::SEG_LA_W,
    parameter int unsigned PA_W = seg_pkg::SEG_PA_W,
    localparam int unsigned SZ_W = LA_W + 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            seg_wr,
    input logic [PA_W-1:0] seg_base_in,
    input logic [SZ_W-1:0] seg_size_in,
    input logic            req_valid,
    input logic            req_ready,
    input logic [LA_W-1:0] req_offset,
    input logic            rsp_valid,
    input logic            rsp_ready,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            rsp_fault
);
    logic [PA_W-1:0] sh_base;
    logic [SZ_W-1:0] sh_size;
    logic [PA_W:0]   sh_sum;
    logic            sh_fault;
    logic [PA_W-1:0] sh_paddr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_base <= '0;
            sh_size <= '0;
        end else if (seg_wr) begin
            sh_base <= seg_base_in;
            sh_size <= seg_size_in;
        end
    end

    always_comb begin
        sh_sum   = (PA_W+1)'(sh_base) + (PA_W+1)'(req_offset);
        sh_fault = ((SZ_W)'(req_offset) >= sh_size) || sh_sum[PA_W];
        sh_paddr = sh_fault ? '0 : sh_sum[PA_W-1:0];
    end

    AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> req_ready); // R1

    AST_RESULT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_paddr == $past(sh_paddr) && rsp_fault == $past(sh_fault))); // R2

    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R3

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid); // R6

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R7

    AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |-> !req_ready); // R7

    AST_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_ready && !req_valid) |=> !rsp_valid); // R7
endmodule

bind seg_xlate seg_xlate_chk #(.LA_W(LA_W), .PA_W(PA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .seg_wr      (seg_wr),
    .seg_base_in (seg_base_in),
    .seg_size_in (seg_size_in),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_offset  (req_offset),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_paddr   (rsp_paddr),
    .rsp_fault   (rsp_fault)
);

// File: tb/tb_seg_xlate.sv
module tb_seg_xlate;
    localparam int unsigned LA_W = 16;
    localparam int unsigned PA_W = 20;
    localparam int unsigned SZ_W = LA_W + 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            seg_wr = 1'b0;
    logic [PA_W-1:0] seg_base_in = '0;
    logic [SZ_W-1:0] seg_size_in = '0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [LA_W-1:0] req_offset = '0;
    logic            rsp_valid;
    logic            rsp_ready = 1'b1;
    logic [PA_W-1:0] rsp_paddr;
    logic            rsp_fault;

    int n_chk = 0;
    int n_bad = 0;
    logic [PA_W-1:0] m_base = '0;
    logic [SZ_W-1:0] m_size = '0;

    always #10 clk = ~clk;   // 50 MHz

    seg_xlate #(.LA_W(LA_W), .PA_W(PA_W)) dut (.*);

    function automatic logic exp_fault(input logic [PA_W-1:0] b, input logic [SZ_W-1:0] s,
                                       input logic [LA_W-1:0] o);
        logic [PA_W:0] sum;
        sum = {1'b0, b} + {5'b0, o};
        return ({1'b0, o} >= s) || sum[PA_W];
    endfunction

    function automatic logic [PA_W-1:0] exp_paddr(input logic [PA_W-1:0] b, input logic [SZ_W-1:0] s,
                                                  input logic [LA_W-1:0] o);
        logic [PA_W:0] sum;
        sum = {1'b0, b} + {5'b0, o};
        return exp_fault(b, s, o) ? '0 : sum[PA_W-1:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_seg(input logic [PA_W-1:0] b, input logic [SZ_W-1:0] s);
        @(negedge clk);
        seg_wr = 1'b1; seg_base_in = b; seg_size_in = s;
        @(posedge clk);
        m_base = b; m_size = s;
        @(negedge clk);
        seg_wr = 1'b0;
    endtask

    // one request with rsp_ready high; checked at the following falling edge
    task automatic xlate(input string req, input logic [LA_W-1:0] o);
        logic            ef;
        logic [PA_W-1:0] ea;
        @(negedge clk);
        req_valid = 1'b1; req_offset = o; rsp_ready = 1'b1;
        ef = exp_fault(m_base, m_size, o);
        ea = exp_paddr(m_base, m_size, o);
        @(negedge clk);
        req_valid = 1'b0;
        check({req, " valid"}, 32'(rsp_valid), 32'd1);
        check({req, " fault"}, 32'(rsp_fault), 32'(ef));
        check({req, " paddr"}, 32'(rsp_paddr), 32'(ea));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [PA_W-1:0] held_a;
        logic            held_f;
        logic            ef;
        logic [PA_W-1:0] ea;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);
        rst_n = 1'b1;
        xlate("R1 zero size faults", 16'h0000);
        @(negedge clk);
        check("R7 drain", 32'(rsp_valid), 32'd0);

        // R2 / R3 boundaries
        load_seg(20'h1_2345, 17'h0100);
        xlate("R2 first", 16'h0000);
        xlate("R2 last in range", 16'h00FF);
        xlate("R3 at size", 16'h0100);
        xlate("R3 far", 16'hFFFF);
        // R8 fault leaves segment intact
        xlate("R8 after fault", 16'h0010);
        // R4 carry out
        load_seg(20'hF_FFF0, 17'h1_0000);
        xlate("R4 no carry edge", 16'h000F);
        xlate("R4 carry", 16'h0010);
        // full size segment
        load_seg(20'h0_0007, 17'h1_0000);
        xlate("R3 full size top", 16'hFFFF);

        // R5 load and request in the same cycle
        @(negedge clk);
        seg_wr = 1'b1; seg_base_in = 20'h4_0000; seg_size_in = 17'h0020;
        req_valid = 1'b1; req_offset = 16'h0030;
        ef = exp_fault(m_base, m_size, 16'h0030);
        ea = exp_paddr(m_base, m_size, 16'h0030);
        @(posedge clk);
        m_base = 20'h4_0000; m_size = 17'h0020;
        @(negedge clk);
        seg_wr = 1'b0; req_valid = 1'b0;
        check("R5 old values fault", 32'(rsp_fault), 32'(ef));
        check("R5 old values paddr", 32'(rsp_paddr), 32'(ea));
        check("R6 one cycle", 32'(rsp_valid), 32'd1);
        xlate("R5 new values apply", 16'h0030);
        xlate("R5 new base", 16'h001F);

        // R7 stall
        @(negedge clk);
        rsp_ready = 1'b0; req_valid = 1'b1; req_offset = 16'h0005;
        @(negedge clk);
        held_a = rsp_paddr; held_f = rsp_fault;
        check("R6 stall resp", 32'(rsp_valid), 32'd1);
        check("R7 paddr", 32'(rsp_paddr), 32'h4_0005);
        req_offset = 16'h0006;
        check("R7 ready low", 32'(req_ready), 32'd0);
        @(negedge clk);
        check("R7 hold valid", 32'(rsp_valid), 32'd1);
        check("R7 hold paddr", 32'(rsp_paddr), 32'(held_a));
        check("R7 hold fault", 32'(rsp_fault), 32'(held_f));
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        check("R7 release", 32'(rsp_valid), 32'd0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 9) == 0) begin
                logic [PA_W-1:0] b;
                logic [SZ_W-1:0] s;
                b = PA_W'($urandom);
                if ($urandom_range(0, 2) == 0) b[PA_W-1 -: 4] = 4'hF;
                s = SZ_W'($urandom_range(0, 32'h1_0000));
                load_seg(b, s);
            end
            if ($urandom_range(0, 1) == 0)
                xlate("R2 random", 16'(m_size - 17'($urandom_range(0, 3))));
            else
                xlate("R3 random", 16'($urandom));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule